// File: doc/BRIEF.md
# Prescaled Reloading Interval Timer

This block produces a periodic tick and interrupt from a slow-clock enable pulse. A power-of-two prescaler divides the incoming slow tick into a base tick, and a 16-bit down-counter counts base ticks. When the down-counter underflows it reloads from the reload value and emits the output tick. The output rate is therefore the base tick rate divided by one plus the reload value.

An interrupt pending flag is set by every output tick and stays set until a clear strobe arrives. The divide code and the reload value are plain inputs, read every cycle. A register file elsewhere holds them. The slow clock itself is generated outside this block and arrives as a one-cycle enable in the system clock domain.

Top module: `interval_timer`

## Requirements
- R1: After reset, `base_tick`, `period_tick` and `irq_pending` are low, and the down-counter starts at FFFFh. The first `period_tick` therefore arrives on the 65536th base tick after reset.
- R2: Divide code n, for n from 0 to 5, makes `base_tick` pulse on every 2^n-th slow tick. Slow ticks are counted from the last prescaler restart, and the pulse falls on the same cycle as that slow tick.
- R3: Divide codes 6 and 7 act as divide by 32.
- R4: The prescaler restarts in any cycle in which `div_code` differs from its value in the previous cycle. In that cycle `base_tick` stays low. The next `base_tick` comes on the 2^n-th slow tick after that cycle.
- R5: `base_tick` is never high without `slow_tick`, and `period_tick` is never high without `base_tick`.
- R6: On a base tick, the down-counter decrements when it is nonzero. When it is zero, `period_tick` pulses in that cycle and the counter reloads from `reload_val`, sampled then. With a steady reload value R, the ticks come every R+1 base ticks.
- R7: A `reload_val` of 0000h is treated as 0001h.
- R8: `irq_pending` is high in the cycle after any `period_tick`.
- R9: When `irq_clear` is high and there is no `period_tick`, `irq_pending` is low in the next cycle. If `period_tick` and `irq_clear` coincide, the set wins. Without a `period_tick`, a low flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle enable at the slow-clock rate |
| div_code | input | 3 | Prescaler divide code (0..5 = divide by 2^n, 6/7 = divide by 32) |
| reload_val | input | 16 | Down-counter reload value |
| irq_clear | input | 1 | Write-one-to-clear strobe for the pending flag |
| base_tick | output | 1 | Prescaled tick |
| period_tick | output | 1 | Underflow tick of the down-counter |
| irq_pending | output | 1 | Interrupt pending flag |

## Verification
The assertions assume that `slow_tick` is a level sampled on the clock. They also assume that the inputs are steady around each rising edge and that reset is held long enough to clear every register. The stimulus changes every input only at the falling edge and holds `slow_tick` low during reset. It varies the slow-tick density between every cycle, random half rate and none at all. It also changes the divide code both while slow ticks arrive and while they do not. This exercises the restart rule under both conditions.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W    = 16,
  parameter int CODE_W   = 3,
  parameter int MAX_CODE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic [CODE_W-1:0] div_code,
  input  logic [CNT_W-1:0]  reload_val,
  input  logic              irq_clear,
  output logic              base_tick,
  output logic              period_tick,
  output logic              irq_pending
);
  localparam int PS_W = MAX_CODE;

  logic [CODE_W-1:0] code_q;
  logic [PS_W-1:0]   ps_cnt;
  logic [CNT_W-1:0]  t_cnt;
  logic              irq_q;

  logic [CODE_W-1:0] sel;
  logic [PS_W-1:0]   mask;
  logic              code_chg;
  logic [CNT_W-1:0]  reload_eff;

  assign sel        = (div_code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : div_code;
  assign mask       = ~({PS_W{1'b1}} << sel);
  assign code_chg   = (div_code != code_q);
  assign reload_eff = (reload_val == '0) ? CNT_W'(1) : reload_val;

  assign base_tick   = slow_tick & ~code_chg & ((ps_cnt & mask) == mask);
  assign period_tick = base_tick & (t_cnt == '0);
  assign irq_pending = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      ps_cnt <= '0;
    end else begin
      code_q <= div_code;
      if (code_chg)       ps_cnt <= '0;
      else if (slow_tick) ps_cnt <= ps_cnt + PS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         t_cnt <= '1;
    else if (base_tick) t_cnt <= (t_cnt == '0) ? reload_eff : t_cnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           irq_q <= 1'b0;
    else if (period_tick) irq_q <= 1'b1;
    else if (irq_clear)   irq_q <= 1'b0;
  end
endmodule

module interval_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic slow_tick,
  input logic irq_clear,
  input logic base_tick,
  input logic period_tick,
  input logic irq_pending
);
  // R5
  base_needs_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |-> slow_tick);
  // R5
  period_needs_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |-> base_tick);
  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |=> irq_pending);
  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !period_tick) |=> !irq_pending);
  // R9
  irq_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pending && !period_tick) |=> !irq_pending);
endmodule

bind interval_timer interval_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .irq_clear(irq_clear),
  .base_tick(base_tick), .period_tick(period_tick), .irq_pending(irq_pending)
);

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic [2:0]  div_code = 3'd0;
  logic [15:0] reload_val = 16'hFFFF;
  logic        irq_clear = 1'b0;
  logic        base_tick, period_tick, irq_pending;

  always #10 clk = ~clk;

  interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .div_code(div_code),
    .reload_val(reload_val), .irq_clear(irq_clear), .base_tick(base_tick),
    .period_tick(period_tick), .irq_pending(irq_pending)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int m_slow_cnt = 0;
  int m_down = 65535;
  int m_prev_code = 0;
  bit m_irq = 0;
  int seen_period = 0;
  string cur_req = "R1";

  function automatic int divisor(int code);
    return 1 << ((code > 5) ? 5 : code);
  endfunction

  task automatic step(input bit s, input int code, input int rv, input bit clr);
    bit eb, ep, ei;
    @(negedge clk);
    slow_tick = s; div_code = 3'(code); reload_val = 16'(rv); irq_clear = clr;
    #1;
    eb = s && (code == m_prev_code) && ((m_slow_cnt % divisor(code)) == divisor(code) - 1);
    ep = eb && (m_down == 0);
    ei = m_irq;
    n_cmp++;
    if (base_tick !== eb || period_tick !== ep || irq_pending !== ei) begin
      n_bad++;
      $display("FAIL %s: base/period/irq actual %b%b%b expected %b%b%b at %0t",
               cur_req, base_tick, period_tick, irq_pending, eb, ep, ei, $time);
    end
    if (ep) seen_period++;
    if (code != m_prev_code) m_slow_cnt = 0;
    else if (s) m_slow_cnt = (m_slow_cnt + 1) % 32;
    m_prev_code = code;
    if (eb) m_down = (m_down == 0) ? ((rv == 0) ? 1 : rv) : m_down - 1;
    m_irq = ep ? 1'b1 : (clr ? 1'b0 : m_irq);
  endtask

  task automatic expect_count(input string req, input int got, input int want);
    n_cmp++;
    if (got != want) begin
      n_bad++;
      $display("FAIL %s: period ticks actual %0d expected %0d", req, got, want);
    end
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: outputs during reset
    repeat (3) begin
      @(negedge clk);
      n_cmp++;
      if (base_tick !== 1'b0 || period_tick !== 1'b0) begin
        n_bad++;
        $display("FAIL R1: ticks in reset actual %b%b expected 00", base_tick, period_tick);
      end
    end
    rst_n = 1'b1;
    n_cmp++;
    #1;
    if (irq_pending !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: irq after reset actual %b expected 0", irq_pending);
    end

    // R1: first underflow after 65536 base ticks
    cur_req = "R1";
    seen_period = 0;
    for (int i = 0; i < 65535; i++) step(1, 0, 3, 0);
    expect_count("R1", seen_period, 0);
    step(1, 0, 3, 0);
    expect_count("R1", seen_period, 1);

    // R6 R8 R9: period of reload+1, occasional clears
    cur_req = "R6";
    seen_period = 0;
    for (int i = 0; i < 400; i++) step(1, 0, 3, (i % 7) == 3);
    expect_count("R6", seen_period, 100);
    cur_req = "R9";
    for (int i = 0; i < 200; i++) step(1, 0, 5, (i % 3) == 0);

    // R2: each legal divisor with sparse slow ticks
    cur_req = "R2";
    for (int c = 1; c <= 5; c++)
      for (int i = 0; i < 600; i++) step(1'($urandom % 2), c, 2, (i % 50) == 0);
    cur_req = "R2";
    seen_period = 0;
    for (int i = 0; i < 5; i++) step(1, 2, 1, 0);
    for (int i = 0; i < 64; i++) step(1, 2, 1, 0);

    // R3: reserved codes
    cur_req = "R3";
    for (int c = 6; c <= 7; c++)
      for (int i = 0; i < 400; i++) step(1, c, 1, 0);
    for (int i = 0; i < 300; i++) step(1'($urandom % 2), 7, 2, 0);

    // R4: frequent code changes
    cur_req = "R4";
    for (int i = 0; i < 1500; i++)
      step(1'($urandom % 4 != 0), ((i % 37) < 30) ? (i / 37) % 8 : $urandom % 8, 1, 0);

    // R7: zero reload acts as one
    cur_req = "R7";
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0);
    seen_period = 0;
    for (int i = 0; i < 100; i++) step(1, 0, 0, 0);
    expect_count("R7", seen_period, 50);

    // R9: clear held high, set wins on coincidence
    cur_req = "R9";
    for (int i = 0; i < 200; i++) step(1, 0, 1, 1);
    for (int i = 0; i < 20; i++) step(0, 0, 1, 1);

    // R5: no slow ticks means no base or period ticks
    cur_req = "R5";
    seen_period = 0;
    for (int i = 0; i < 300; i++) step(0, $urandom % 8, $urandom % 4, 0);
    expect_count("R5", seen_period, 0);

    // R8: mixed traffic with rare clears
    cur_req = "R8";
    for (int i = 0; i < 2000; i++)
      step(1'($urandom % 2), (i / 250) % 8, $urandom % 6, ($urandom % 20) == 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule